// File: doc/BRIEF.md
# Set-Associative Write-Back Data Cache Controller

This block is a small data cache that sits between a processor port and a slower line-oriented memory. A byte address is split into three fields: a byte offset inside the line, a set index, and a tag. The index selects one line in every way, and all ways compare their tags at the same time. A read hit returns a word. A write hit updates only the cached copy and marks the line dirty.

On a miss the controller picks a victim way. Any invalid way is taken first. When every way is valid, a binary-tree pseudo-LRU chooses the victim. If the victim holds modified data, the controller first sends that line to memory, then fetches the requested line. A write miss allocates: the fetched line is merged with the new word before it is stored. The processor port is stalled from acceptance until the response. The replacement tree is refreshed on every access, on hits and on misses alike.

The processor request is valid/ready: a request must stay stable while `req_valid` is high until `req_ready` is seen, and `req_ready` is high only when the controller is idle. The response is a one-cycle `rsp_valid` pulse with no back-pressure. The memory request is also valid/ready: the controller holds address, direction and data stable until `mem_req_ready`. Memory answers each accepted read with exactly one `mem_rsp_valid` pulse carrying the whole line, which the controller always accepts.

Top module: `wb_cache_ctrl`

## Requirements
- R1: With defaults (12-bit byte address, 32-bit words, 4 words per line, 4 sets, 4 ways), bits [3:0] select the byte in the line (bits [3:2] pick the word), bits [5:4] are the set index and bits [11:6] are the tag. `mem_req_addr` carries the line address {tag, index}, which is the byte address shifted right by 4.
- R2: A read hit returns the stored word with `rsp_valid` high in the cycle after the first clock edge that follows the accepting edge, and it makes no memory request.
- R3: A write hit updates only the cached word, makes no memory request, and the new value is returned by later reads.
- R4: A write miss fetches the line from memory, replaces the addressed word with the write data, and keeps the other words of that line as fetched.
- R5: When the victim is valid and dirty, the controller writes its whole line to its own line address before it issues the refill read. A clean or invalid victim causes no memory write.
- R6: When the indexed set has an invalid way, the controller fills it, taking the lowest-numbered invalid way, before it evicts any valid line.
- R7: In a full set the victim follows the 3-bit pseudo-LRU tree from its root. Each access, hit or refill, sets every tree bit on the path to the used way so that it points away from that way.
- R8: `req_ready` is low from the accepting edge until the response cycle has ended. `rsp_valid` lasts exactly one cycle and is followed by `req_ready` high.
- R9: While `mem_req_valid` is high and `mem_req_ready` is low, the memory request fields are held stable. Each accepted read consumes exactly one line response.
- R10: After reset every line is invalid, `req_ready` is high, and neither `rsp_valid` nor `mem_req_valid` is asserted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Processor request present |
| req_ready | output | 1 | Controller can accept a request (idle) |
| req_write | input | 1 | 1 = word write, 0 = word read |
| req_addr | input | ADDR_W | Byte address of the word |
| req_wdata | input | WORD_W | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | WORD_W | Read data (meaningful for reads) |
| mem_req_valid | output | 1 | Line request to memory present |
| mem_req_ready | input | 1 | Memory accepts the line request |
| mem_req_write | output | 1 | 1 = line writeback, 0 = line fetch |
| mem_req_addr | output | ADDR_W-4 | Line address {tag, index} |
| mem_req_wdata | output | LINE_W | Line data for a writeback |
| mem_rsp_valid | input | 1 | Fetched line delivered |
| mem_rsp_rdata | input | LINE_W | Fetched line data |

## Verification
A hit gives its response one edge after the accepting edge. The bench therefore samples on falling edges and counts falling edges from acceptance until `rsp_valid`, expecting exactly one for a hit. On misses the wait is open-ended, bounded only by the memory model's variable ready and its three-cycle read latency, so those checks trigger on `rsp_valid` rather than on a fixed cycle. The memory model records the cycle and line address of every accepted read and write. Writeback-before-refill ordering and victim identity are judged from those records only after the response has arrived, when both transfers are complete.

// File: rtl/cache_pkg.sv
package cache_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LOOKUP,
    ST_EVICT,
    ST_FILL,
    ST_RESP
  } cache_state_e;
endpackage

// File: rtl/plru_tree.sv
module plru_tree #(
  parameter int WAYS  = 4,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS-2:0]  bits_i,
  input  logic [WAY_W-1:0] touch_way_i,
  output logic [WAYS-2:0]  bits_o,
  output logic [WAY_W-1:0] victim_o
);
  // node n has children 2n+1 (left, lower ways) and 2n+2 (right)
  always_comb begin
    int node;
    bits_o = bits_i;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      bits_o[node] = ~touch_way_i[WAY_W-1-l];
      node = 2 * node + 1 + int'(touch_way_i[WAY_W-1-l]);
    end
  end

  always_comb begin
    int node;
    victim_o = '0;
    node = 0;
    for (int l = 0; l < WAY_W; l++) begin
      victim_o[WAY_W-1-l] = bits_i[node];
      node = 2 * node + 1 + int'(bits_i[node]);
    end
  end
endmodule

// File: rtl/way_match.sv
module way_match #(
  parameter int WAYS  = 4,
  parameter int TAG_W = 6,
  parameter int WAY_W = $clog2(WAYS)
) (
  input  logic [WAYS*TAG_W-1:0] tags_i,
  input  logic [WAYS-1:0]       valid_i,
  input  logic [TAG_W-1:0]      tag_i,
  output logic                  hit_o,
  output logic [WAY_W-1:0]      hit_way_o,
  output logic                  free_o,
  output logic [WAY_W-1:0]      free_way_o
);
  logic [WAYS-1:0] match;

  for (genvar g = 0; g < WAYS; g++) begin : g_cmp
    assign match[g] = valid_i[g] && (tags_i[g*TAG_W +: TAG_W] == tag_i);
  end

  assign hit_o  = |match;
  assign free_o = ~&valid_i;

  // scan downward so the lowest index is the one kept
  always_comb begin
    hit_way_o  = '0;
    free_way_o = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (match[w])    hit_way_o  = WAY_W'(w);
      if (!valid_i[w]) free_way_o = WAY_W'(w);
    end
  end
endmodule

// File: rtl/wb_cache_ctrl.sv
module wb_cache_ctrl
  import cache_pkg::*;
#(
  parameter int ADDR_W     = 12,
  parameter int WORD_W     = 32,
  parameter int LINE_WORDS = 4,
  parameter int SETS       = 4,
  parameter int WAYS       = 4,
  localparam int BYTE_W    = $clog2(WORD_W / 8),
  localparam int WSEL_W    = $clog2(LINE_WORDS),
  localparam int OFF_W     = BYTE_W + WSEL_W,
  localparam int IDX_W     = $clog2(SETS),
  localparam int TAG_W     = ADDR_W - OFF_W - IDX_W,
  localparam int LINE_W    = WORD_W * LINE_WORDS,
  localparam int LADDR_W   = ADDR_W - OFF_W,
  localparam int WAY_W     = $clog2(WAYS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_valid,
  output logic               req_ready,
  input  logic               req_write,
  input  logic [ADDR_W-1:0]  req_addr,
  input  logic [WORD_W-1:0]  req_wdata,
  output logic               rsp_valid,
  output logic [WORD_W-1:0]  rsp_rdata,
  output logic               mem_req_valid,
  input  logic               mem_req_ready,
  output logic               mem_req_write,
  output logic [LADDR_W-1:0] mem_req_addr,
  output logic [LINE_W-1:0]  mem_req_wdata,
  input  logic               mem_rsp_valid,
  input  logic [LINE_W-1:0]  mem_rsp_rdata
);
  // storage
  logic [LINE_W-1:0] data_q  [SETS][WAYS];
  logic [TAG_W-1:0]  tag_q   [SETS][WAYS];
  logic [WAYS-1:0]   valid_q [SETS];
  logic [WAYS-1:0]   dirty_q [SETS];
  logic [WAYS-2:0]   plru_q  [SETS];

  // request context
  cache_state_e      st_q;
  logic [ADDR_W-1:0] addr_q;
  logic              wr_q;
  logic [WORD_W-1:0] wdata_q;
  logic [WAY_W-1:0]  vic_q;
  logic              issued_q;
  logic [WORD_W-1:0] rdata_q;

  logic [IDX_W-1:0]  idx;
  logic [TAG_W-1:0]  tag;
  logic [WSEL_W-1:0] wsel;
  assign idx  = addr_q[OFF_W +: IDX_W];
  assign tag  = addr_q[ADDR_W-1 -: TAG_W];
  assign wsel = addr_q[BYTE_W +: WSEL_W];

  logic [WAYS*TAG_W-1:0] set_tags;
  always_comb begin
    for (int w = 0; w < WAYS; w++) set_tags[w*TAG_W +: TAG_W] = tag_q[idx][w];
  end

  logic             hit, free;
  logic [WAY_W-1:0] hit_way, free_way, plru_vic, victim_sel, touch_way;
  logic [WAYS-2:0]  plru_next;

  way_match #(.WAYS(WAYS), .TAG_W(TAG_W)) u_match (
    .tags_i(set_tags), .valid_i(valid_q[idx]), .tag_i(tag),
    .hit_o(hit), .hit_way_o(hit_way), .free_o(free), .free_way_o(free_way)
  );

  assign touch_way = (st_q == ST_LOOKUP) ? hit_way : vic_q;

  plru_tree #(.WAYS(WAYS)) u_plru (
    .bits_i(plru_q[idx]), .touch_way_i(touch_way),
    .bits_o(plru_next), .victim_o(plru_vic)
  );

  assign victim_sel = free ? free_way : plru_vic;

  logic [LINE_W-1:0] hit_line, hit_merged, fill_merged;
  always_comb begin
    hit_line    = data_q[idx][hit_way];
    hit_merged  = hit_line;
    hit_merged[wsel*WORD_W +: WORD_W] = wdata_q;
    fill_merged = mem_rsp_rdata;
    fill_merged[wsel*WORD_W +: WORD_W] = wdata_q;
  end

  logic lookup_hit, fill_done;
  assign lookup_hit = (st_q == ST_LOOKUP) && hit;
  assign fill_done  = (st_q == ST_FILL) && issued_q && mem_rsp_valid;

  // ports
  assign req_ready     = (st_q == ST_IDLE);
  assign rsp_valid     = (st_q == ST_RESP);
  assign rsp_rdata     = rdata_q;
  assign mem_req_write = (st_q == ST_EVICT);
  assign mem_req_valid = (st_q == ST_EVICT) || ((st_q == ST_FILL) && !issued_q);
  assign mem_req_addr  = (st_q == ST_EVICT) ? {tag_q[idx][vic_q], idx} : {tag, idx};
  assign mem_req_wdata = data_q[idx][vic_q];

  // line arrays carry no reset: valid bits gate every use
  always_ff @(posedge clk) begin
    if (lookup_hit && wr_q) data_q[idx][hit_way] <= hit_merged;
    if (fill_done) begin
      data_q[idx][vic_q] <= wr_q ? fill_merged : mem_rsp_rdata;
      tag_q[idx][vic_q]  <= tag;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q     <= ST_IDLE;
      addr_q   <= '0;
      wr_q     <= 1'b0;
      wdata_q  <= '0;
      vic_q    <= '0;
      issued_q <= 1'b0;
      rdata_q  <= '0;
      for (int s = 0; s < SETS; s++) begin
        valid_q[s] <= '0;
        dirty_q[s] <= '0;
        plru_q[s]  <= '0;
      end
    end else begin
      unique case (st_q)
        ST_IDLE: if (req_valid) begin
          addr_q  <= req_addr;
          wr_q    <= req_write;
          wdata_q <= req_wdata;
          st_q    <= ST_LOOKUP;
        end
        ST_LOOKUP: begin
          if (hit) begin
            plru_q[idx] <= plru_next;
            rdata_q     <= hit_line[wsel*WORD_W +: WORD_W];
            if (wr_q) dirty_q[idx][hit_way] <= 1'b1;
            st_q <= ST_RESP;
          end else begin
            vic_q    <= victim_sel;
            issued_q <= 1'b0;
            st_q     <= (valid_q[idx][victim_sel] && dirty_q[idx][victim_sel])
                        ? ST_EVICT : ST_FILL;
          end
        end
        ST_EVICT: if (mem_req_ready) st_q <= ST_FILL;
        ST_FILL: begin
          if (mem_req_valid && mem_req_ready) issued_q <= 1'b1;
          if (fill_done) begin
            valid_q[idx][vic_q] <= 1'b1;
            dirty_q[idx][vic_q] <= wr_q;
            plru_q[idx]         <= plru_next;
            rdata_q             <= mem_rsp_rdata[wsel*WORD_W +: WORD_W];
            st_q                <= ST_RESP;
          end
        end
        ST_RESP: st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wb_cache_ctrl_chk.sv
module wb_cache_ctrl_chk #(
  parameter int LADDR_W = 8,
  parameter int LINE_W  = 128
) (
  input logic               clk,
  input logic               rst_n,
  input logic               req_valid,
  input logic               req_ready,
  input logic               rsp_valid,
  input logic               mem_req_valid,
  input logic               mem_req_ready,
  input logic               mem_req_write,
  input logic [LADDR_W-1:0] mem_req_addr,
  input logic [LINE_W-1:0]  mem_req_wdata
);
  // R8: an accepted request stalls the port
  a_r8_stall_after_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready);

  // R8: one-cycle response, then ready again
  a_r8_single_rsp: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> (!rsp_valid && req_ready));

  // R9: memory request held while stalled
  a_r9_hold_mem_req: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=>
      (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)
       && $stable(mem_req_wdata)));

  // R5: a writeback is followed at once by the refill read
  a_r5_wb_then_fill: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && mem_req_ready && mem_req_write) |=>
      (mem_req_valid && !mem_req_write));

  // R10: no memory traffic while the port is idle
  a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_req_valid);

  // R8: no response while idle
  a_r8_no_rsp_idle: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !rsp_valid);
endmodule

bind wb_cache_ctrl wb_cache_ctrl_chk #(.LADDR_W(LADDR_W), .LINE_W(LINE_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .rsp_valid(rsp_valid), .mem_req_valid(mem_req_valid),
  .mem_req_ready(mem_req_ready), .mem_req_write(mem_req_write),
  .mem_req_addr(mem_req_addr), .mem_req_wdata(mem_req_wdata)
);

// File: tb/wb_cache_ctrl_tb_top.sv
module wb_cache_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NLINES = 256;
  localparam int NWORDS = 1024;
  localparam int NVEC = 16;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic         req_write = 1'b0;
  logic [11:0]  req_addr = '0;
  logic [31:0]  req_wdata = '0;
  logic         rsp_valid;
  logic [31:0]  rsp_rdata;
  logic         mem_req_valid;
  logic         mem_req_ready;
  logic         mem_req_write;
  logic [7:0]   mem_req_addr;
  logic [127:0] mem_req_wdata;
  logic         mem_rsp_valid;
  logic [127:0] mem_rsp_rdata;

  always #(CLK_PERIOD/2) clk = ~clk;

  wb_cache_ctrl dut_i (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_rdata(mem_rsp_rdata)
  );

  // lower memory model with stuttering ready and 3-cycle read latency
  logic [127:0] lmem [NLINES];
  logic [31:0]  ref_mem [NWORDS];
  int cyc = 0, wb_count = 0, rd_count = 0, wb_time = 0, rd_time = 0;
  logic [7:0] last_wb_addr = '0, last_rd_addr = '0, pend_addr = '0;
  int pend = 0;
  logic rdy_q = 1'b0;
  assign mem_req_ready = rdy_q;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    rdy_q <= rst_n ? ~rdy_q : 1'b0;
    mem_rsp_valid <= 1'b0;
    if (rst_n && mem_req_valid && mem_req_ready) begin
      if (mem_req_write) begin
        lmem[mem_req_addr] <= mem_req_wdata;
        wb_count <= wb_count + 1;
        last_wb_addr <= mem_req_addr;
        wb_time <= cyc;
      end else begin
        pend <= 3;
        pend_addr <= mem_req_addr;
        rd_count <= rd_count + 1;
        last_rd_addr <= mem_req_addr;
        rd_time <= cyc;
      end
    end
    if (pend != 0) begin
      pend <= pend - 1;
      if (pend == 1) begin
        mem_rsp_valid <= 1'b1;
        mem_rsp_rdata <= lmem[pend_addr];
      end
    end
  end

  int checks = 0, failures = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    req_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  // one processor access; lat counts falling edges from acceptance to rsp
  task automatic access(input bit w, input logic [11:0] a, input logic [31:0] d,
                        output logic [31:0] rd, output int lat);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
    lat = 0;
    while (!rsp_valid && lat < 200) begin
      if (req_ready) chk(1'b0, "R8 ready during stall", 1, 0);
      @(negedge clk);
      lat++;
    end
    rd = rsp_rdata;
    if (w) ref_mem[a[11:2]] = d;
  endtask

  // {write, addr, data}
  localparam logic [44:0] VEC [NVEC] = '{
    {1'b1, 12'h000, 32'h11111111}, {1'b1, 12'h044, 32'h22222222},
    {1'b0, 12'h000, 32'h0},        {1'b1, 12'h088, 32'h33333333},
    {1'b1, 12'h0CC, 32'h44444444}, {1'b0, 12'h044, 32'h0},
    {1'b1, 12'h104, 32'h55555555}, {1'b1, 12'h148, 32'h66666666},
    {1'b0, 12'h000, 32'h0},        {1'b0, 12'h088, 32'h0},
    {1'b0, 12'h0CC, 32'h0},        {1'b0, 12'h104, 32'h0},
    {1'b0, 12'h148, 32'h0},        {1'b0, 12'h01C, 32'h0},
    {1'b1, 12'h01C, 32'h77777777}, {1'b0, 12'h01C, 32'h0}
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    int lat, wb0, rd0;
    for (int i = 0; i < NWORDS; i++) begin
      ref_mem[i] = 32'h5A00_0000 | i;
      lmem[i/4][(i%4)*32 +: 32] = 32'h5A00_0000 | i;
    end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);
    chk(mem_req_valid == 1'b0 && rsp_valid == 1'b0, "R10 quiet after reset",
        {mem_req_valid, rsp_valid}, 0);

    // table walk: every read against reference memory (R3 R4 R5)
    for (int v = 0; v < NVEC; v++) begin
      logic [31:0] exp;
      exp = ref_mem[VEC[v][43:34]];
      access(VEC[v][44], VEC[v][43:32], VEC[v][31:0], rd, lat);
      if (!VEC[v][44]) chk(rd == exp, "R5 read vs reference", rd, exp);
    end

    // R1 field split and line address; R2 hit latency, no traffic
    rd0 = rd_count;
    access(1'b0, 12'h2A4, 32'h0, rd, lat);
    chk(last_rd_addr == 8'h2A, "R1 line address", last_rd_addr, 8'h2A);
    chk(rd == (32'h5A00_0000 | 32'h0A9), "R1 word select", rd, 32'h5A00_0000 | 32'h0A9);
    chk(rd_count == rd0 + 1, "R9 one fetch per miss", rd_count, rd0 + 1);
    rd0 = rd_count; wb0 = wb_count;
    access(1'b0, 12'h2A4, 32'h0, rd, lat);
    chk(lat == 1, "R2 hit latency", lat, 1);
    chk(rd_count == rd0 && wb_count == wb0, "R2 hit no traffic", rd_count, rd0);

    // R3 write hit
    access(1'b1, 12'h2A8, 32'hDEADBEEF, rd, lat);
    chk(lat == 1 && rd_count == rd0 && wb_count == wb0, "R3 write hit local", lat, 1);
    access(1'b0, 12'h2A8, 32'h0, rd, lat);
    chk(rd == 32'hDEADBEEF, "R3 write hit readback", rd, 32'hDEADBEEF);

    // R4 write-allocate into empty set 3
    access(1'b1, 12'h3F0, 32'hCAFEF00D, rd, lat);
    chk(rd_count == rd0 + 1 && wb_count == wb0, "R4 allocate fetch", rd_count, rd0 + 1);
    access(1'b0, 12'h3F4, 32'h0, rd, lat);
    chk(rd == ref_mem[10'h3F4 >> 2], "R4 neighbour word kept", rd, ref_mem[10'h3F4 >> 2]);
    access(1'b0, 12'h3F0, 32'h0, rd, lat);
    chk(rd == 32'hCAFEF00D, "R4 merged word", rd, 32'hCAFEF00D);

    // fresh cache; reference follows what memory actually holds
    do_reset();
    repeat (2) @(negedge clk);
    for (int i = 0; i < NWORDS; i++) ref_mem[i] = lmem[i/4][(i%4)*32 +: 32];

    // R6 invalid ways fill first: four dirty lines in set 2, nothing evicted
    rd0 = rd_count; wb0 = wb_count;
    access(1'b1, 12'h020, 32'hA0A0A0A0, rd, lat);
    access(1'b1, 12'h060, 32'hB0B0B0B0, rd, lat);
    access(1'b1, 12'h0A0, 32'hC0C0C0C0, rd, lat);
    access(1'b1, 12'h0E0, 32'hD0D0D0D0, rd, lat);
    chk(wb_count == wb0 && rd_count == rd0 + 4, "R6 fill without eviction", wb_count, wb0);
    rd0 = rd_count;
    access(1'b0, 12'h020, 32'h0, rd, lat);
    access(1'b0, 12'h060, 32'h0, rd, lat);
    access(1'b0, 12'h0A0, 32'h0, rd, lat);
    access(1'b0, 12'h0E0, 32'h0, rd, lat);
    chk(rd_count == rd0, "R6 all four resident", rd_count, rd0);

    // R7 hit on way0 moves victim to way2 (line 0x0A); R5 writeback first
    access(1'b0, 12'h020, 32'h0, rd, lat);
    wb0 = wb_count;
    access(1'b1, 12'h120, 32'hE0E0E0E0, rd, lat);
    chk(wb_count == wb0 + 1, "R5 dirty victim written", wb_count, wb0 + 1);
    chk(last_wb_addr == 8'h0A, "R7 victim after hit update", last_wb_addr, 8'h0A);
    chk(wb_time < rd_time, "R5 writeback before refill", wb_time, rd_time);
    chk(lmem[8'h0A][31:0] == 32'hC0C0C0C0, "R5 writeback data", lmem[8'h0A][31:0], 32'hC0C0C0C0);
    access(1'b0, 12'h0A0, 32'h0, rd, lat);
    chk(rd == 32'hC0C0C0C0, "R5 evicted data returns", rd, 32'hC0C0C0C0);
    chk(last_wb_addr == 8'h06, "R7 next victim way1", last_wb_addr, 8'h06);

    // R5 clean victims: five reads in set 0 produce no writeback
    wb0 = wb_count; rd0 = rd_count;
    for (int t = 0; t < 5; t++) access(1'b0, 12'(t * 64), 32'h0, rd, lat);
    chk(wb_count == wb0 && rd_count == rd0 + 5, "R5 clean eviction silent", wb_count, wb0);
    chk(rd == ref_mem[10'h40], "R5 clean refill data", rd, ref_mem[10'h40]);

    done = 1'b1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule